// File: doc/BRIEF.md
# Pulse-Interval Frame Decoder

This block is the receive side of a contactless card that is addressed by pulse-pause modulation. The reader marks each bit with a short carrier pause, so the card only needs to time the gap between successive rising edges of its digitised envelope. A long gap means a one and a short gap means a zero. Any gap that fits neither nominal period, within a symmetric tolerance, is treated as invalid. Timing is counted in pulses of a tick enable, not in clock cycles, so the same decoder works with any tick rate that keeps the nominal periods.

Decoded bits are placed into a frame register with the earliest bit in bit 0. A frame ends when no edge arrives within the one-period plus tolerance, or when an invalid gap arrives while a frame is being collected. A closed frame with enough bits is presented for exactly one cycle with a valid strobe, and then the register clears. Shorter frames, which are usually noise, are dropped without any output. Decryption and command decoding belong to the logic downstream.

Top module: `pid_decoder`

## Requirements
- R1: After reset, frameValid is 0, frameData is 0 and bitCount is 0.
- R2: An interval of T ticks between rising edges with OneTicks−FuzzTicks < T < OneTicks+FuzzTicks (defaults 150 and 20, so 131 to 169) decodes as bit value 1. The values 130 and 170 do not.
- R3: An interval with ZeroTicks−FuzzTicks < T < ZeroTicks+FuzzTicks (default ZeroTicks 90, so 71 to 109) decodes as bit value 0. The values 70 and 110 do not.
- R4: An interval outside both windows closes the frame being collected. When no frame is being collected, such an interval is ignored and leaves no trace in later frames.
- R5: While a frame is being collected, reaching OneTicks+FuzzTicks ticks with no new rising edge closes the frame. The strobe follows within a few cycles of that count.
- R6: A closed frame holding MinBits−1 (default 4) bits or fewer produces no strobe. One holding MinBits or more produces exactly one strobe.
- R7: Bits are stored LSB-first: the first decoded bit is at frameData bit 0, the n-th at bit n−1. During the strobe, bitCount equals the number of bits stored.
- R8: At most MaxBits (default 31) bits are stored. Later bits in the same frame are dropped and bitCount stays at MaxBits.
- R9: frameValid is high for one cycle only. In the following cycle, frameData and bitCount are 0.
- R10: The interval counter stops at StopMult×OneTicks (default 3000) ticks. An edge after any longer idle gap is invalid and is never mistaken for a bit because of counter wrap.
- R11: Only cycles with tickEn high advance the interval measurement. The envelope passes through a two-flop synchroniser, which delays every edge by the same amount and so leaves intervals unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| envIn | input | 1 | Digitised carrier envelope, asynchronous |
| tickEn | input | 1 | Time-base tick; one interval unit per high cycle |
| frameValid | output | 1 | One-cycle strobe marking a delivered frame |
| frameData | output | MaxBits (31) | Received bits, first bit in bit 0 |
| bitCount | output | clog2(MaxBits+1) (5) | Number of valid bits in frameData |

## Verification
Directed interval lists place edges one tick inside and one tick outside each tolerance window. These lists show whether the window comparisons are strict and whether an invalid gap splits a frame into two. Other directed lists cover frames of four, five and thirty-six bits, an invalid gap while idle, and an idle gap longer than the counter range, which separate runt suppression, bit capping and counter saturation. Random mixes of ones, zeros and invalid gaps are also applied, first with a tick on every cycle and then with sparse random ticks. The random-tick runs show whether the decoder counts ticks or clock cycles. Every strobed frame is compared with an interval-level model of the requirements.

// File: rtl/pid_pkg.sv
package pid_pkg;

  // Class of the interval that ended at the current rising edge
  typedef enum logic [1:0] {
    IV_NONE = 2'd0,  // no edge this cycle
    IV_ZERO = 2'd1,
    IV_ONE  = 2'd2,
    IV_BAD  = 2'd3
  } ivClass_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic appendBit;
    logic bitVal;
    logic clearFrame;
  } frameCtl_t;

endpackage

// File: rtl/pid_datapath.sv
module pid_datapath
  import pid_pkg::*;
#(
  parameter int OneTicks   = 150,
  parameter int ZeroTicks  = 90,
  parameter int FuzzTicks  = 20,
  parameter int StopLimit  = 3000,
  parameter int CntW       = 12,
  parameter int MaxBits    = 31,
  parameter int CountW     = 5,
  parameter int SyncStages = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              envIn,
  input  logic              tickEn,
  input  frameCtl_t         ctl,
  output ivClass_e          ivClass,
  output logic [CntW-1:0]   intervalCnt,
  output logic [MaxBits-1:0] frameData,
  output logic [CountW-1:0] bitCount
);

  localparam logic [CntW-1:0]   CntMax   = CntW'(StopLimit);
  localparam logic [CountW-1:0] CountMax = CountW'(MaxBits);

  // Synchroniser and edge detector
  logic [SyncStages-1:0] syncQ;
  logic                  envPrev;
  logic                  rise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      envPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SyncStages-2:0], envIn};
      envPrev <= syncQ[SyncStages-1];
    end
  end

  assign rise = syncQ[SyncStages-1] & ~envPrev;

  // Interval counter: restart on edge, count ticks, stop at the limit.
  // Reset leaves it at the limit so the first edge reads as idle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= CntMax;
    end else if (rise) begin
      intervalCnt <= tickEn ? CntW'(1) : '0;
    end else if (tickEn && intervalCnt < CntMax) begin
      intervalCnt <= intervalCnt + CntW'(1);
    end
  end

  // Tolerance windows: index 0 for the zero period, index 1 for the one period
  logic [1:0] winHit;
  for (genvar g = 0; g < 2; g++) begin : g_win
    localparam int Nom = (g == 0) ? ZeroTicks : OneTicks;
    assign winHit[g] = (int'(intervalCnt) > Nom - FuzzTicks) &&
                       (int'(intervalCnt) < Nom + FuzzTicks);
  end

  always_comb begin
    if (!rise)          ivClass = IV_NONE;
    else if (winHit[1]) ivClass = IV_ONE;
    else if (winHit[0]) ivClass = IV_ZERO;
    else                ivClass = IV_BAD;
  end

  // Frame register, LSB-first, capped at MaxBits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameData <= '0;
      bitCount  <= '0;
    end else if (ctl.clearFrame) begin
      frameData <= '0;
      bitCount  <= '0;
    end else if (ctl.appendBit && bitCount < CountMax) begin
      frameData[bitCount] <= ctl.bitVal;
      bitCount            <= bitCount + CountW'(1);
    end
  end

endmodule

// File: rtl/pid_control.sv
module pid_control
  import pid_pkg::*;
#(
  parameter int OneTicks  = 150,
  parameter int FuzzTicks = 20,
  parameter int MinBits   = 5,
  parameter int CntW      = 12,
  parameter int CountW    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ivClass_e          ivClass,
  input  logic [CntW-1:0]   intervalCnt,
  input  logic [CountW-1:0] bitCount,
  output frameCtl_t         ctl,
  output logic              frameValid
);

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_PRESENT} ctlState_e;

  ctlState_e state, nextState;
  logic      timeoutHit;
  logic      enoughBits;
  logic      isBit;

  assign timeoutHit = int'(intervalCnt) >= OneTicks + FuzzTicks;
  assign enoughBits = int'(bitCount) >= MinBits;
  assign isBit      = (ivClass == IV_ONE) || (ivClass == IV_ZERO);

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        // invalid edges are ignored here
        if (isBit) begin
          ctl.appendBit = 1'b1;
          ctl.bitVal    = (ivClass == IV_ONE);
          nextState     = ST_COLLECT;
        end
      end
      ST_COLLECT: begin
        if (isBit) begin
          ctl.appendBit = 1'b1;
          ctl.bitVal    = (ivClass == IV_ONE);
        end else if (ivClass == IV_BAD || timeoutHit) begin
          if (enoughBits) begin
            nextState = ST_PRESENT;
          end else begin
            ctl.clearFrame = 1'b1;  // runt: drop silently
            nextState      = ST_IDLE;
          end
        end
      end
      ST_PRESENT: begin
        ctl.clearFrame = 1'b1;
        nextState      = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign frameValid = (state == ST_PRESENT);

endmodule

// File: rtl/pid_decoder.sv
module pid_decoder
  import pid_pkg::*;
#(
  parameter int OneTicks   = 150,
  parameter int ZeroTicks  = 90,
  parameter int FuzzTicks  = 20,
  parameter int StopMult   = 20,
  parameter int MaxBits    = 31,
  parameter int MinBits    = 5,
  parameter int SyncStages = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         envIn,
  input  logic                         tickEn,
  output logic                         frameValid,
  output logic [MaxBits-1:0]           frameData,
  output logic [$clog2(MaxBits+1)-1:0] bitCount
);

  localparam int StopLimit = StopMult * OneTicks;
  localparam int CntW      = $clog2(StopLimit + 1);
  localparam int CountW    = $clog2(MaxBits + 1);

  frameCtl_t       ctl;
  ivClass_e        ivClass;
  logic [CntW-1:0] intervalCnt;

  pid_datapath #(
    .OneTicks(OneTicks), .ZeroTicks(ZeroTicks), .FuzzTicks(FuzzTicks),
    .StopLimit(StopLimit), .CntW(CntW), .MaxBits(MaxBits),
    .CountW(CountW), .SyncStages(SyncStages)
  ) u_dp (
    .clk(clk), .rstN(rstN), .envIn(envIn), .tickEn(tickEn), .ctl(ctl),
    .ivClass(ivClass), .intervalCnt(intervalCnt),
    .frameData(frameData), .bitCount(bitCount)
  );

  pid_control #(
    .OneTicks(OneTicks), .FuzzTicks(FuzzTicks), .MinBits(MinBits),
    .CntW(CntW), .CountW(CountW)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .ivClass(ivClass), .intervalCnt(intervalCnt),
    .bitCount(bitCount), .ctl(ctl), .frameValid(frameValid)
  );

endmodule

// File: rtl/pid_decoder_chk.sv
module pid_decoder_chk #(
  parameter int MaxBits   = 31,
  parameter int MinBits   = 5,
  parameter int StopLimit = 3000,
  parameter int CntW      = 12,
  parameter int CountW    = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               frameValid,
  input logic [MaxBits-1:0] frameData,
  input logic [CountW-1:0]  bitCount,
  input logic [CntW-1:0]    intervalCnt
);

  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid);

  a_r9_clear_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> (bitCount == '0 && frameData == '0));

  a_r6_no_runt_strobe: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> int'(bitCount) >= MinBits);

  a_r8_count_cap: assert property (@(posedge clk) disable iff (!rstN)
    int'(bitCount) <= MaxBits);

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (bitCount != $past(bitCount)) |->
      (bitCount == $past(bitCount) + CountW'(1) || bitCount == '0));

  a_r10_counter_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(intervalCnt) <= StopLimit);

endmodule

bind pid_decoder pid_decoder_chk #(
  .MaxBits(MaxBits), .MinBits(MinBits), .StopLimit(StopLimit),
  .CntW(CntW), .CountW(CountW)
) u_chk (
  .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameData(frameData),
  .bitCount(bitCount), .intervalCnt(intervalCnt)
);

// File: tb/pid_decoder_tb.sv
module pid_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ONE        = 150;
  localparam int ZERO       = 90;
  localparam int FUZZ       = 20;
  localparam int MAXB       = 31;
  localparam int MINB       = 5;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        envIn = 1'b0;
  logic        tickEn = 1'b0;
  logic        frameValid;
  logic [30:0] frameData;
  logic [4:0]  bitCount;

  pid_decoder u_dut (
    .clk(clk), .rstN(rstN), .envIn(envIn), .tickEn(tickEn),
    .frameValid(frameValid), .frameData(frameData), .bitCount(bitCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int          nChecks = 0;
  int          nFails = 0;
  bit          tickMode = 1'b0;
  bit          done = 1'b0;
  bit          prevValid = 1'b0;
  int          seqQ[$];
  logic [30:0] expD[$];
  int          expC[$];
  logic [30:0] logD[$];
  int          logC[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Strobe monitor, samples away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (prevValid)
        check(!frameValid && bitCount == 0 && frameData == 0, "R9",
              "state after strobe", {frameValid, bitCount, frameData}, 0);
      if (frameValid) begin
        logD.push_back(frameData);
        logC.push_back(int'(bitCount));
      end
      prevValid = frameValid;
    end
  end

  task automatic driveTick();
    tickEn = tickMode ? 1'($urandom % 2) : 1'b1;
  endtask

  task automatic idleTicks(input int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      driveTick();
      if (tickEn) seen++;
    end
  endtask

  // Rising edge n ticks after the previous one
  task automatic edgeTicks(input int n);
    int seen = 0;
    int cyc = 0;
    while (seen < n) begin
      @(negedge clk);
      driveTick();
      if (tickEn) seen++;
      if (seen == n)   envIn = 1'b1;
      else if (cyc < 3) envIn = 1'b1;
      else             envIn = 1'b0;
      cyc++;
    end
  endtask

  function automatic int pickOne();
    return tickMode ? int'($urandom_range(160, 140)) : int'($urandom_range(169, 131));
  endfunction

  function automatic int pickZero();
    return tickMode ? int'($urandom_range(100, 80)) : int'($urandom_range(109, 71));
  endfunction

  function automatic int pickBad();
    int r = int'($urandom % 3);
    if (r == 0) return int'($urandom_range(60, 20));
    if (r == 1) return tickMode ? int'($urandom_range(125, 115)) : int'($urandom_range(130, 110));
    return tickMode ? int'($urandom_range(300, 185)) : int'($urandom_range(300, 170));
  endfunction

  // Interval-level model of the requirements
  task automatic buildExpect();
    bit          active = 1'b0;
    int          cnt = 0;
    logic [30:0] data = '0;
    expD.delete();
    expC.delete();
    foreach (seqQ[i]) begin
      int  v = seqQ[i];
      bit  isOne = (v > ONE - FUZZ) && (v < ONE + FUZZ);
      bit  isZero = (v > ZERO - FUZZ) && (v < ZERO + FUZZ);
      if (isOne || isZero) begin
        if (cnt < MAXB) begin
          data[cnt] = isOne;
          cnt++;
        end
        active = 1'b1;
      end else if (active) begin
        if (cnt >= MINB) begin expD.push_back(data); expC.push_back(cnt); end
        cnt = 0; data = '0; active = 1'b0;
      end
    end
    if (active && cnt >= MINB) begin expD.push_back(data); expC.push_back(cnt); end
  endtask

  task automatic runSeq(input string tag);
    buildExpect();
    idleTicks(250);
    logD.delete();
    logC.delete();
    edgeTicks(8);
    foreach (seqQ[i]) edgeTicks(seqQ[i]);
    idleTicks(250);
    check(logD.size() == expD.size(), tag, "frame count", logD.size(), expD.size());
    for (int i = 0; i < logD.size() && i < expD.size(); i++) begin
      check(logD[i] == expD[i], tag, "frame data", logD[i], expD[i]);
      check(logC[i] == expC[i], tag, "bit count", logC[i], expC[i]);
    end
  endtask

  task automatic pushN(input int v, input int n);
    for (int i = 0; i < n; i++) seqQ.push_back(v);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd715));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(frameValid == 0 && frameData == 0 && bitCount == 0, "R1", "reset state",
          {frameValid, bitCount, frameData}, 0);

    // R7: LSB-first ordering, bits 1,0,1,1,0,0,1 -> 0x4D
    seqQ = '{ONE, ZERO, ONE, ONE, ZERO, ZERO, ONE};
    runSeq("R7");
    check(logD.size() == 1 && logD[0] == 31'h4D && logC[0] == 7, "R7", "explicit frame",
          logD.size() > 0 ? longint'(logD[0]) : -1, 'h4D);

    // R2: inside-edge values decode as one
    seqQ.delete(); pushN(ONE, 5); seqQ.push_back(131); seqQ.push_back(169); pushN(ONE, 5);
    runSeq("R2");
    // R2: 130 and 170 split the frame
    seqQ.delete(); pushN(ONE, 5); seqQ.push_back(130); pushN(ONE, 5);
    runSeq("R2");
    seqQ.delete(); pushN(ONE, 5); seqQ.push_back(170); pushN(ONE, 5);
    runSeq("R2");

    // R3: zero window boundaries
    seqQ.delete(); pushN(ZERO, 5); seqQ.push_back(71); seqQ.push_back(109); pushN(ZERO, 2);
    runSeq("R3");
    seqQ.delete(); pushN(ZERO, 5); seqQ.push_back(70); pushN(ZERO, 5);
    runSeq("R3");
    seqQ.delete(); pushN(ZERO, 5); seqQ.push_back(110); pushN(ZERO, 5);
    runSeq("R3");

    // R4: invalid gaps while idle are ignored
    seqQ = '{40, 40}; pushN(ONE, 3); pushN(ZERO, 2);
    runSeq("R4");
    check(logC.size() == 1 && logC[0] == 5, "R4", "idle invalid ignored",
          logC.size() > 0 ? logC[0] : -1, 5);

    // R6: runt suppression
    seqQ.delete(); pushN(ONE, 4);
    runSeq("R6");
    seqQ.delete(); pushN(ZERO, 5);
    runSeq("R6");
    seqQ.delete(); pushN(ONE, 4); seqQ.push_back(40); pushN(ZERO, 5);
    runSeq("R6");

    // R8: cap at 31 bits
    seqQ.delete();
    for (int i = 0; i < 36; i++) seqQ.push_back((i % 3 == 0) ? ZERO : ONE);
    runSeq("R8");
    check(logC.size() == 1 && logC[0] == MAXB, "R8", "capped count",
          logC.size() > 0 ? logC[0] : -1, MAXB);

    // R10: gap longer than counter range, then four bits -> nothing
    seqQ = '{4246}; pushN(ONE, 4);
    runSeq("R10");

    // R5: timeout timing after the last edge
    seqQ.delete(); pushN(ONE, 6);
    idleTicks(250);
    logD.delete(); logC.delete();
    edgeTicks(8);
    foreach (seqQ[i]) edgeTicks(seqQ[i]);
    idleTicks(160);
    check(logD.size() == 0, "R5", "no strobe before timeout", logD.size(), 0);
    idleTicks(20);
    check(logD.size() == 1 && logC[0] == 6, "R5", "strobe after timeout",
          logD.size(), 1);

    // Random mixes, one tick per cycle
    for (int s = 0; s < 16; s++) begin
      int len = int'($urandom_range(20, 1));
      seqQ.delete();
      for (int i = 0; i < len; i++) begin
        int r = int'($urandom % 10);
        seqQ.push_back(r == 0 ? pickBad() : (r < 5 ? pickOne() : pickZero()));
      end
      runSeq("R2/R3 random");
    end

    // Random mixes with sparse random ticks
    tickMode = 1'b1;
    for (int s = 0; s < 8; s++) begin
      int len = int'($urandom_range(14, 1));
      seqQ.delete();
      for (int i = 0; i < len; i++) begin
        int r = int'($urandom % 10);
        seqQ.push_back(r == 0 ? pickBad() : (r < 5 ? pickOne() : pickZero()));
      end
      runSeq("R11");
    end
    tickMode = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end

endmodule